// File: doc/BRIEF.md
# Real-Mode Address Generator with A20 Gate

This block turns a 16-bit segment and a 16-bit offset into a physical byte address in the same way a real-mode processor does. The segment is multiplied by sixteen and the offset is added to it. The sum can reach 0x10FFEF, which is one bit wider than the classic 1 MB space. Before the sum reaches the 24-bit address bus, it passes through an A20 gate. While the gate is closed, bit 20 and every bit above it are cleared. Addresses just past 1 MB therefore fold back onto the bottom 64 KB, which is what legacy software expects.

The gate opens when any one of three sources is active:
- a level from a keyboard-controller model;
- a fast-gate bit held in an 8-bit control register that software reaches through I/O port 0x92;
- a latch that is set by any read of I/O port 0xEE and cleared by any write to that port.

The I/O side is a plain strobe interface with an 8-bit address and 8-bit data. The address path is purely combinational. The gate registers change only on a rising clock edge on which an I/O strobe is present. After reset the gate is closed.

Top module: `rm_a20_addr_gen`

## Requirements
- R1: While the gate is open, `addr_o` equals (`seg_i` × 16 + `off_i`) with no truncation. At `seg_i`=0xFFFF and `off_i`=0xFFFF this gives 0x10FFEF. The output follows the inputs in the same cycle.
- R2: While the gate is closed, `addr_o` equals (`seg_i` × 16 + `off_i`) modulo 2^20. For example, 0xFFFF:0xFFFF gives 0x00FFEF.
- R3: A clock edge with `rst_n` low clears the port 0x92 register to 0x00 and clears the 0xEE latch, so with `kbc_gate_i` low `a20_open_o` is 0.
- R4: A write strobe to address 0x92 stores the whole data byte at that edge. Bit 1 of the stored byte is the fast-gate bit. The other seven bits are kept but do not affect the gate.
- R5: While `io_rd_i` is high and `io_addr_i` is 0x92, `io_rdata_o` shows the current port 0x92 register in the same cycle. Every other read returns 0x00.
- R6: A read strobe to address 0xEE sets the latch at that edge and opens the gate. A write strobe to 0xEE clears the latch, whatever the data byte.
- R7: `kbc_gate_i` high opens the gate combinationally, with no clock edge needed.
- R8: `a20_open_o` is the OR of `kbc_gate_i`, port 0x92 bit 1 and the 0xEE latch. The gate stays open until all three are low.
- R9: Strobes to any address other than 0x92 and 0xEE leave both gate registers unchanged.
- R10: If read and write strobes to 0xEE arrive in the same cycle, the write wins and the latch ends up cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| seg_i | input | 16 | Segment value |
| off_i | input | 16 | Offset within the segment |
| kbc_gate_i | input | 1 | Gate level from the keyboard-controller model |
| io_addr_i | input | 8 | I/O port address |
| io_wr_i | input | 1 | I/O write strobe |
| io_rd_i | input | 1 | I/O read strobe |
| io_wdata_i | input | 8 | I/O write data |
| io_rdata_o | output | 8 | I/O read data |
| a20_open_o | output | 1 | Current state of the gate, 1 = open |
| addr_o | output | 24 | Physical address after the gate |

## Verification
A wrong fast-gate bit or a wrong latch shows up as a wrong `a20_open_o`. It also shows up as a wrong bit 20 on `addr_o` for any address at or above 1 MB. Both are visible in the cycle right after the strobe edge that should have changed the state. A corrupted port 0x92 byte is visible at once through a read of 0x92, even when bit 1 is still correct. Faults in the adder or in the mask show up without any clock, so they are swept over segment and offset patterns that cross the 1 MB boundary, with the gate both closed and open.

// File: rtl/rm_a20_pkg.sv
// Shared definitions for the real-mode address generator.
// Assumes: I/O port decode produces at most one target per access.
package rm_a20_pkg;

    // Which gate register an I/O access targets
    typedef enum logic [1:0] {
        IO_SEL_NONE   = 2'd0,
        IO_SEL_FAST   = 2'd1,
        IO_SEL_TOGGLE = 2'd2
    } io_sel_e;

    // Default port numbers and fast-gate bit position
    localparam logic [7:0] FAST_PORT_DEF   = 8'h92;
    localparam logic [7:0] TOGGLE_PORT_DEF = 8'hEE;
    localparam int         FAST_BIT_DEF    = 1;

endpackage

// File: rtl/rm_addr_calc.sv
// Combinational segment:offset adder.
// Computes (seg << SHIFT) + off at full width, so the carry into the
// top bit is kept. Assumes LIN_W >= max(SEG_W + SHIFT, OFF_W) + 1.
module rm_addr_calc #(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    parameter int LIN_W = 21
) (
    input  logic [SEG_W-1:0] seg_i,
    input  logic [OFF_W-1:0] off_i,
    output logic [LIN_W-1:0] lin_o
);

    // Shift the segment and add the zero-extended offset
    always_comb begin
        lin_o = (LIN_W'(seg_i) << SHIFT) + LIN_W'(off_i);
    end

endmodule

// File: rtl/rm_a20_mask.sv
// Gate mask for the linear address.
// Bits below GATE_BIT pass unchanged. Bits from GATE_BIT upward pass only
// while gate_i is high. Bus bits beyond the linear width are driven to 0.
// Assumes BUS_W >= LIN_W and GATE_BIT < LIN_W.
module rm_a20_mask #(
    parameter int LIN_W    = 21,
    parameter int BUS_W    = 24,
    parameter int GATE_BIT = 20
) (
    input  logic [LIN_W-1:0] lin_i,
    input  logic             gate_i,
    output logic [BUS_W-1:0] addr_o
);

    // One mask cell per bus bit; the bit's position picks the cell's form
    for (genvar i = 0; i < BUS_W; i++) begin : g_bit
        if (i < GATE_BIT) begin : g_pass
            assign addr_o[i] = lin_i[i];
        end else if (i < LIN_W) begin : g_gated
            assign addr_o[i] = lin_i[i] & gate_i;
        end else begin : g_zero
            assign addr_o[i] = 1'b0;
        end
    end

endmodule

// File: rtl/rm_gate_ports.sv
// I/O decoder holding the two software-controlled gate sources:
//   - a full-byte fast-gate register at FAST_PORT (gate bit FAST_BIT);
//   - a latch set by a read of TOGGLE_PORT and cleared by a write to it.
// Registers update on the rising edge on which a strobe is present.
// Reset is synchronous and active low. Read data is combinational.
module rm_gate_ports
    import rm_a20_pkg::*;
#(
    parameter int              IO_AW       = 8,
    parameter int              IO_DW       = 8,
    parameter logic [IO_AW-1:0] FAST_PORT   = IO_AW'(FAST_PORT_DEF),
    parameter logic [IO_AW-1:0] TOGGLE_PORT = IO_AW'(TOGGLE_PORT_DEF),
    parameter int              FAST_BIT    = FAST_BIT_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IO_AW-1:0] io_addr_i,
    input  logic             io_wr_i,
    input  logic             io_rd_i,
    input  logic [IO_DW-1:0] io_wdata_i,
    output logic [IO_DW-1:0] io_rdata_o,
    output logic             fast_gate_o,
    output logic             latch_gate_o
);

    io_sel_e          sel;
    logic [IO_DW-1:0] fast_q;
    logic             latch_q;

    // Decode the port address into a register select
    always_comb begin
        if (io_addr_i == FAST_PORT)        sel = IO_SEL_FAST;
        else if (io_addr_i == TOGGLE_PORT) sel = IO_SEL_TOGGLE;
        else                               sel = IO_SEL_NONE;
    end

    // Fast-gate register: cleared by reset, loaded by a write to its port
    always_ff @(posedge clk) begin
        if (!rst_n)                             fast_q <= '0;
        else if (io_wr_i && sel == IO_SEL_FAST) fast_q <= io_wdata_i;
    end

    // Toggle latch: a write clears it, a read sets it, and a write wins
    always_ff @(posedge clk) begin
        if (!rst_n)                                latch_q <= 1'b0;
        else if (io_wr_i && sel == IO_SEL_TOGGLE) latch_q <= 1'b0;
        else if (io_rd_i && sel == IO_SEL_TOGGLE) latch_q <= 1'b1;
    end

    // Read mux: only the fast-gate register can be read back
    always_comb begin
        io_rdata_o = (io_rd_i && sel == IO_SEL_FAST) ? fast_q : '0;
    end

    assign fast_gate_o  = fast_q[FAST_BIT];
    assign latch_gate_o = latch_q;

    // R3
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (fast_q == '0 && !latch_q));

    // R4
    fast_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr_i && io_addr_i == FAST_PORT) |=> fast_q == $past(io_wdata_i));

    // R6
    toggle_read_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd_i && !io_wr_i && io_addr_i == TOGGLE_PORT) |=> latch_gate_o);

    // R10
    toggle_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr_i && io_addr_i == TOGGLE_PORT) |=> !latch_gate_o);

    // R9
    other_port_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_addr_i != FAST_PORT && io_addr_i != TOGGLE_PORT)
        |=> ($stable(fast_q) && $stable(latch_q)));

endmodule

// File: rtl/rm_a20_addr_gen.sv
// Top: real-mode address generator with A20 gate.
// The gate is open when the keyboard-controller level, the fast-gate bit or
// the toggle latch is high. The address path is combinational from
// seg_i/off_i to addr_o. Assumes a single clock and synchronous active-low reset.
module rm_a20_addr_gen
    import rm_a20_pkg::*;
#(
    parameter int SEG_W    = 16,
    parameter int OFF_W    = 16,
    parameter int SHIFT    = 4,
    parameter int BUS_W    = 24,
    parameter int GATE_BIT = 20,
    parameter int IO_AW    = 8,
    parameter int IO_DW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEG_W-1:0] seg_i,
    input  logic [OFF_W-1:0] off_i,
    input  logic             kbc_gate_i,
    input  logic [IO_AW-1:0] io_addr_i,
    input  logic             io_wr_i,
    input  logic             io_rd_i,
    input  logic [IO_DW-1:0] io_wdata_i,
    output logic [IO_DW-1:0] io_rdata_o,
    output logic             a20_open_o,
    output logic [BUS_W-1:0] addr_o
);

    localparam int SUM_W = ((SEG_W + SHIFT) > OFF_W) ? (SEG_W + SHIFT) : OFF_W;
    localparam int LIN_W = SUM_W + 1;

    logic [LIN_W-1:0] lin;
    logic             fast_gate;
    logic             latch_gate;

    rm_addr_calc #(
        .SEG_W (SEG_W),
        .OFF_W (OFF_W),
        .SHIFT (SHIFT),
        .LIN_W (LIN_W)
    ) i_calc (
        .seg_i (seg_i),
        .off_i (off_i),
        .lin_o (lin)
    );

    rm_gate_ports #(
        .IO_AW (IO_AW),
        .IO_DW (IO_DW)
    ) i_ports (
        .clk          (clk),
        .rst_n        (rst_n),
        .io_addr_i    (io_addr_i),
        .io_wr_i      (io_wr_i),
        .io_rd_i      (io_rd_i),
        .io_wdata_i   (io_wdata_i),
        .io_rdata_o   (io_rdata_o),
        .fast_gate_o  (fast_gate),
        .latch_gate_o (latch_gate)
    );

    // Combine the three gate sources
    always_comb begin
        a20_open_o = kbc_gate_i | fast_gate | latch_gate;
    end

    rm_a20_mask #(
        .LIN_W    (LIN_W),
        .BUS_W    (BUS_W),
        .GATE_BIT (GATE_BIT)
    ) i_mask (
        .lin_i  (lin),
        .gate_i (a20_open_o),
        .addr_o (addr_o)
    );

    // R2
    closed_no_high_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !a20_open_o |-> addr_o[BUS_W-1:GATE_BIT] == '0);

    // R7
    kbc_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kbc_gate_i |-> a20_open_o);

endmodule

// File: tb/test_rm_a20_addr_gen.sv
`timescale 1ns/1ps
module test_rm_a20_addr_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] seg = '0;
    logic [15:0] off = '0;
    logic        kbc = 1'b0;
    logic [7:0]  io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        a20_open;
    logic [23:0] addr;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    rm_a20_addr_gen i_rm_a20_addr_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .seg_i      (seg),
        .off_i      (off),
        .kbc_gate_i (kbc),
        .io_addr_i  (io_addr),
        .io_wr_i    (io_wr),
        .io_rd_i    (io_rd),
        .io_wdata_i (io_wdata),
        .io_rdata_o (io_rdata),
        .a20_open_o (a20_open),
        .addr_o     (addr)
    );

    // Watchdog: a hung run counts as a failure and still prints the summary
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer than 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Drive at the falling edge, let one rising edge act, and release
    task automatic io_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        #1;
    endtask

    // Sample the data before the rising edge, then release after it
    task automatic io_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1 d = io_rdata;
        @(negedge clk);
        io_rd = 1'b0;
        #1;
    endtask

    function automatic logic [15:0] pick_off(input int k);
        case (k)
            0: return 16'h0000;
            1: return 16'h0001;
            2: return 16'h000F;
            3: return 16'h0010;
            4: return 16'h7FFF;
            5: return 16'h8000;
            6: return 16'hFFEF;
            default: return 16'hFFFF;
        endcase
    endfunction

    // Sweep segments around and below the 1 MB boundary; R1 when open, R2 when closed
    task automatic sweep(input bit open);
        for (int s = 0; s < 2048 + 256; s++) begin
            seg = (s < 2048) ? 16'(16'hF800 + s) : 16'((s - 2048) * 257);
            for (int k = 0; k < 8; k++) begin
                logic [23:0] lin;
                off = pick_off(k);
                #1;
                lin = ({8'h0, seg} << 4) + {8'h0, off};
                if (open) check("R1 open address", 32'(addr), 32'(lin));
                else      check("R2 closed wrap", 32'(addr), 32'(lin & 24'h0FFFFF));
            end
        end
    endtask

    initial begin
        logic [7:0] rd;
        // Reset
        repeat (3) @(negedge clk);
        #1;
        check("R3 reset gate closed", 32'(a20_open), 32'd0);
        rst_n = 1'b1;
        io_read(8'h92, rd);
        check("R3 reset fast register", 32'(rd), 32'h00);

        // Boundary values, gate closed
        seg = 16'hFFFF; off = 16'hFFFF; #1;
        check("R2 top wraps", 32'(addr), 32'h00FFEF);
        seg = 16'hF000; off = 16'h0000; #1;
        check("R2 below 1MB intact", 32'(addr), 32'h0F0000);
        sweep(1'b0);

        // Keyboard-controller source
        kbc = 1'b1; #1;
        check("R7 kbc opens", 32'(a20_open), 32'd1);
        seg = 16'hFFFF; off = 16'hFFFF; #1;
        check("R1 max address", 32'(addr), 32'h10FFEF);
        sweep(1'b1);
        kbc = 1'b0; #1;
        check("R7 kbc release closes", 32'(a20_open), 32'd0);

        // Fast-gate register
        io_write(8'h92, 8'h02);
        check("R4 fast bit opens", 32'(a20_open), 32'd1);
        seg = 16'hFFFF; off = 16'h0010; #1;
        check("R4 open address", 32'(addr), 32'h100000);
        io_read(8'h92, rd);
        check("R5 readback 0x02", 32'(rd), 32'h02);
        io_write(8'h92, 8'hFD);
        check("R4 other bits no gate", 32'(a20_open), 32'd0);
        check("R4 closed address", 32'(addr), 32'h000000);
        io_read(8'h92, rd);
        check("R5 readback 0xFD", 32'(rd), 32'hFD);
        io_write(8'h92, 8'h00);

        // Toggle port
        io_read(8'hEE, rd);
        check("R5 toggle read data", 32'(rd), 32'h00);
        check("R6 read opens", 32'(a20_open), 32'd1);
        io_write(8'hEE, 8'hFF);
        check("R6 write closes", 32'(a20_open), 32'd0);

        // Other ports are ignored
        io_write(8'h93, 8'hFF);
        io_write(8'hED, 8'h02);
        io_read(8'hEF, rd);
        check("R5 other read zero", 32'(rd), 32'h00);
        check("R9 gate untouched", 32'(a20_open), 32'd0);
        io_read(8'h92, rd);
        check("R9 fast register untouched", 32'(rd), 32'h00);

        // Simultaneous read and write on the toggle port
        io_read(8'hEE, rd);
        check("R10 latch set first", 32'(a20_open), 32'd1);
        @(negedge clk);
        io_addr = 8'hEE; io_wr = 1'b1; io_rd = 1'b1;
        @(negedge clk);
        io_wr = 1'b0; io_rd = 1'b0; #1;
        check("R10 write wins", 32'(a20_open), 32'd0);

        // OR of the sources
        io_write(8'h92, 8'h02);
        io_read(8'hEE, rd);
        kbc = 1'b1;
        io_write(8'h92, 8'h00);
        check("R8 latch and kbc keep open", 32'(a20_open), 32'd1);
        kbc = 1'b0; #1;
        check("R8 latch alone keeps open", 32'(a20_open), 32'd1);
        io_write(8'hEE, 8'h00);
        check("R8 all low closes", 32'(a20_open), 32'd0);

        // Reset in mid-run
        io_write(8'h92, 8'h06);
        io_read(8'hEE, rd);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; #1;
        check("R3 mid-run reset closes", 32'(a20_open), 32'd0);
        io_read(8'h92, rd);
        check("R3 mid-run reset register", 32'(rd), 32'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule